// File: doc/BRIEF.md
# Interrupt Acknowledge Cycle Sequencer

This block runs the processor side of an interrupt acknowledge. When a request strobe arrives with a pending priority level, it opens a CPU-space bus cycle. The function code and a fixed all-ones address carry the level in three bits. In the cycle after the bus opens, it copies that level from the address into the interrupt-priority field of a status register. At the accepting edge it also clears a page-extension field.

It then waits for one of several outcomes:
- a bus error;
- an autovector request;
- the arbitration verdict, with or without a dominant source;
- an external responder's ready with a vector on the data lines;
- a timeout.

Each outcome picks one of the vector-generation paths. The chosen vector number is reported together with its word-indexed table address, a code naming the path, and a one-cycle done strobe.

The sequencer sits between the interrupt arbitration logic and the exception entry logic. The exception entry logic uses the table address to fetch the handler.

Top module: `iack_seq`

## Requirements
- R1: After reset, bus_act, done, fc, addr, sr_ipl, sr_pk, vec_num, vec_addr and vec_src are all zero. While bus_act is low, fc and addr stay zero.
- R2: An ack_req seen while idle makes bus_act high from the next cycle. While bus_act is high, fc is 3'b111 and addr[23:4] is all ones. addr[3:1] holds the accepted level and addr[0] is 1.
- R3: One cycle after bus_act rises, sr_ipl equals the level taken from addr[3:1], and it holds that value until the next acknowledge.
- R4: While idle, a pk_wr loads pk_wdata into sr_pk. At the edge that accepts ack_req, sr_pk becomes 0, even if pk_wr is presented in the same cycle.
- R5: If arb_done is high with arb_win low, the vector is the spurious number 0x0F and vec_src is 1.
- R6: If arb_done and arb_win are both high, the vector is arb_vec and vec_src is 2.
- R7: If avec is high, the vector is 0x10 plus the level and vec_src is 3.
- R8: If berr is high, the vector is 0x0F and vec_src is 4. Bus error outranks autovector, which outranks arbitration, which outranks external ready.
- R9: If ext_rdy is high with no other outcome, the vector is ext_data and vec_src is 6.
- R10: If no outcome arrives within TMO_CYC cycles of bus_act high (default 16), the vector is 0x0F with vec_src 5. The end comes at the TMO_CYC-th cycle.
- R11: An outcome seen at an edge while bus_act is high gives, after that edge, done high for exactly one cycle, bus_act low, and vec_addr equal to vec_num shifted left by one.
- R12: Outcome inputs while idle change neither done nor the vector outputs. An ack_req while busy does not change the level on addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_req | input | 1 | Start an acknowledge for ack_level |
| ack_level | input | 3 | Pending interrupt priority level |
| pk_wr | input | 1 | Write strobe for the page-extension field |
| pk_wdata | input | 4 | Page-extension write data |
| arb_done | input | 1 | Arbitration verdict valid |
| arb_win | input | 1 | A dominant source exists |
| arb_vec | input | 8 | Vector from the dominant source |
| avec | input | 1 | Autovector request |
| berr | input | 1 | Bus error |
| ext_rdy | input | 1 | External responder terminates the cycle |
| ext_data | input | 8 | External vector on the data lines |
| bus_act | output | 1 | Acknowledge cycle in progress |
| fc | output | 3 | Function code |
| addr | output | 24 | Address bus |
| sr_ipl | output | 3 | Status-register interrupt-priority field |
| sr_pk | output | 4 | Page-extension field |
| vec_num | output | 8 | Selected vector number |
| vec_addr | output | 9 | Vector table address |
| vec_src | output | 3 | Path that produced the vector |
| done | output | 1 | One-cycle completion strobe |

## Verification
Counting edges from the one that accepts ack_req:
- The bus outputs and the cleared page field are due one cycle later.
- sr_ipl is due one further cycle on.
- Vector, address, source code and done appear one cycle after the edge that samples an outcome.
- A silent cycle ends at the TMO_CYC-th acknowledge edge.

The bench drives inputs and samples outputs at the falling edge, then advances by a counted number of rising edges before each comparison. This places every check in the exact cycle its result is due. Every level from 1 to 7 is swept against every path and several response delays, with the expected vectors worked out arithmetically.

// File: rtl/iack_pkg.sv
package iack_pkg;
    typedef enum logic [2:0] {
        SRC_NONE  = 3'd0,
        SRC_NOWIN = 3'd1,
        SRC_WIN   = 3'd2,
        SRC_AUTO  = 3'd3,
        SRC_BERR  = 3'd4,
        SRC_TMO   = 3'd5,
        SRC_EXT   = 3'd6
    } vsrc_e;
endpackage

// File: rtl/iack_addr_gen.sv
module iack_addr_gen #(
    parameter int LVL_W  = 3,
    parameter int ADDR_W = 24,
    parameter int FC_W   = 3
) (
    input  logic              active,
    input  logic [LVL_W-1:0]  level,
    output logic [FC_W-1:0]   fc,
    output logic [ADDR_W-1:0] addr
);
    localparam int HI_W = ADDR_W - LVL_W - 1;

    always_comb begin
        if (active) begin
            fc   = '1;
            addr = {{HI_W{1'b1}}, level, 1'b1};
        end else begin
            fc   = '0;
            addr = '0;
        end
    end
endmodule

// File: rtl/iack_vec_sel.sv
module iack_vec_sel
    import iack_pkg::*;
#(
    parameter int          LVL_W     = 3,
    parameter int          VEC_W     = 8,
    parameter logic [7:0]  SPUR_VEC  = 8'h0F,
    parameter logic [7:0]  AUTO_BASE = 8'h10
) (
    input  logic             active,
    input  logic [LVL_W-1:0] level,
    input  logic             berr,
    input  logic             avec,
    input  logic             arb_done,
    input  logic             arb_win,
    input  logic [VEC_W-1:0] arb_vec,
    input  logic             ext_rdy,
    input  logic [VEC_W-1:0] ext_data,
    input  logic             expire,
    output logic             hit,
    output logic [VEC_W-1:0] vec,
    output vsrc_e            src
);
    localparam logic [VEC_W-1:0] SPUR_W = VEC_W'(SPUR_VEC);
    localparam logic [VEC_W-1:0] BASE_W = VEC_W'(AUTO_BASE);

    always_comb begin
        hit = active;
        vec = '0;
        src = SRC_NONE;
        if (berr) begin
            vec = SPUR_W;
            src = SRC_BERR;
        end else if (avec) begin
            vec = BASE_W + VEC_W'(level);
            src = SRC_AUTO;
        end else if (arb_done && !arb_win) begin
            vec = SPUR_W;
            src = SRC_NOWIN;
        end else if (arb_done && arb_win) begin
            vec = arb_vec;
            src = SRC_WIN;
        end else if (ext_rdy) begin
            vec = ext_data;
            src = SRC_EXT;
        end else if (expire) begin
            vec = SPUR_W;
            src = SRC_TMO;
        end else begin
            hit = 1'b0;
        end
    end
endmodule

// File: rtl/iack_tmo.sv
module iack_tmo #(
    parameter int TMO_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CNT_W = (TMO_CYC < 2) ? 1 : $clog2(TMO_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmo_st_t;

    tmo_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run || st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign expire = run && (st_q.cnt == LAST);

    AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> st_q.cnt == '0); // R10
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST); // R10
endmodule

// File: rtl/iack_seq.sv
module iack_seq
    import iack_pkg::*;
#(
    parameter int         LVL_W     = 3,
    parameter int         ADDR_W    = 24,
    parameter int         FC_W      = 3,
    parameter int         VEC_W     = 8,
    parameter int         PK_W      = 4,
    parameter int         TMO_CYC   = 16,
    parameter logic [7:0] SPUR_VEC  = 8'h0F,
    parameter logic [7:0] AUTO_BASE = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_req,
    input  logic [LVL_W-1:0]  ack_level,
    input  logic              pk_wr,
    input  logic [PK_W-1:0]   pk_wdata,
    input  logic              arb_done,
    input  logic              arb_win,
    input  logic [VEC_W-1:0]  arb_vec,
    input  logic              avec,
    input  logic              berr,
    input  logic              ext_rdy,
    input  logic [VEC_W-1:0]  ext_data,
    output logic              bus_act,
    output logic [FC_W-1:0]   fc,
    output logic [ADDR_W-1:0] addr,
    output logic [LVL_W-1:0]  sr_ipl,
    output logic [PK_W-1:0]   sr_pk,
    output logic [VEC_W-1:0]  vec_num,
    output logic [VEC_W:0]    vec_addr,
    output logic [2:0]        vec_src,
    output logic              done
);
    localparam int VA_W = VEC_W + 1;

    typedef struct packed {
        logic             busy;
        logic [LVL_W-1:0] lvl;
        logic             ipl_pend;
        logic [LVL_W-1:0] ipl;
        logic [PK_W-1:0]  pk;
        logic [VEC_W-1:0] vec;
        logic [VA_W-1:0]  vaddr;
        vsrc_e            src;
        logic             done;
    } seq_st_t;

    seq_st_t st_d, st_q;

    logic             hit;
    logic [VEC_W-1:0] sel_vec;
    vsrc_e            sel_src;
    logic             expire;

    iack_addr_gen #(
        .LVL_W (LVL_W),
        .ADDR_W(ADDR_W),
        .FC_W  (FC_W)
    ) u_addr (
        .active(st_q.busy),
        .level (st_q.lvl),
        .fc    (fc),
        .addr  (addr)
    );

    iack_tmo #(
        .TMO_CYC(TMO_CYC)
    ) u_tmo (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q.busy),
        .expire(expire)
    );

    iack_vec_sel #(
        .LVL_W    (LVL_W),
        .VEC_W    (VEC_W),
        .SPUR_VEC (SPUR_VEC),
        .AUTO_BASE(AUTO_BASE)
    ) u_sel (
        .active  (st_q.busy),
        .level   (st_q.lvl),
        .berr    (berr),
        .avec    (avec),
        .arb_done(arb_done),
        .arb_win (arb_win),
        .arb_vec (arb_vec),
        .ext_rdy (ext_rdy),
        .ext_data(ext_data),
        .expire  (expire),
        .hit     (hit),
        .vec     (sel_vec),
        .src     (sel_src)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.ipl_pend) begin
            st_d.ipl      = addr[LVL_W:1];
            st_d.ipl_pend = 1'b0;
        end
        if (!st_q.busy) begin
            if (pk_wr) begin
                st_d.pk = pk_wdata;
            end
            if (ack_req) begin
                st_d.busy     = 1'b1;
                st_d.lvl      = ack_level;
                st_d.ipl_pend = 1'b1;
                st_d.pk       = '0;
            end
        end else begin
            if (pk_wr) begin
                st_d.pk = pk_wdata;
            end
            if (hit) begin
                st_d.busy  = 1'b0;
                st_d.vec   = sel_vec;
                st_d.vaddr = {sel_vec, 1'b0};
                st_d.src   = sel_src;
                st_d.done  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_act  = st_q.busy;
    assign sr_ipl   = st_q.ipl;
    assign sr_pk    = st_q.pk;
    assign vec_num  = st_q.vec;
    assign vec_addr = st_q.vaddr;
    assign vec_src  = st_q.src;
    assign done     = st_q.done;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_act |-> (fc == '0 && addr == '0)); // R1
    AST_FC_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        bus_act |-> fc == '1); // R2
    AST_ADDR_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        bus_act |-> (addr[ADDR_W-1:LVL_W+1] == '1 && addr[0])); // R2
    AST_IPL_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_act) |=> sr_ipl == $past(addr[LVL_W:1])); // R3
    AST_PK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_act) |-> sr_pk == '0); // R4
    AST_AUTO_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_act && avec && !berr) |=> vec_num == VEC_W'(AUTO_BASE) + VEC_W'($past(addr[LVL_W:1]))); // R7
    AST_BERR_SPUR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_act && berr) |=> (done && vec_num == VEC_W'(SPUR_VEC))); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_DONE_ENDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bus_act); // R11
    AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_act && !done) |=> !done); // R12
endmodule

// File: tb/sim_iack_seq.sv
module sim_iack_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ack_req = 1'b0;
    logic [2:0] ack_level = '0;
    logic       pk_wr = 1'b0;
    logic [3:0] pk_wdata = '0;
    logic       arb_done = 1'b0;
    logic       arb_win = 1'b0;
    logic [7:0] arb_vec = '0;
    logic       avec = 1'b0;
    logic       berr = 1'b0;
    logic       ext_rdy = 1'b0;
    logic [7:0] ext_data = '0;
    logic        bus_act;
    logic [2:0]  fc;
    logic [23:0] addr;
    logic [2:0]  sr_ipl;
    logic [3:0]  sr_pk;
    logic [7:0]  vec_num;
    logic [8:0]  vec_addr;
    logic [2:0]  vec_src;
    logic        done;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    iack_seq u0 (
        .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .ack_level(ack_level),
        .pk_wr(pk_wr), .pk_wdata(pk_wdata), .arb_done(arb_done), .arb_win(arb_win),
        .arb_vec(arb_vec), .avec(avec), .berr(berr), .ext_rdy(ext_rdy),
        .ext_data(ext_data), .bus_act(bus_act), .fc(fc), .addr(addr),
        .sr_ipl(sr_ipl), .sr_pk(sr_pk), .vec_num(vec_num), .vec_addr(vec_addr),
        .vec_src(vec_src), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_resp();
        arb_done = 0; arb_win = 0; avec = 0; berr = 0; ext_rdy = 0;
    endtask

    // path: 0 nowin, 1 win, 2 auto, 3 berr, 4 ext, 5 timeout
    task automatic trial(input int lvl, input int path, input int dly);
        int exp_vec;
        int exp_src;
        int waits;
        ack_req = 1; ack_level = 3'(lvl);
        step();
        ack_req = 0;
        chk(bus_act == 1 && fc == 3'b111, "R2 fc", int'(fc), 7);
        chk(addr == {20'hFFFFF, 3'(lvl), 1'b1}, "R2 addr", int'(addr),
            int'({20'hFFFFF, 3'(lvl), 1'b1}));
        chk(sr_pk == 0, "R4 pk clear", int'(sr_pk), 0);
        waits = (path == 5) ? 15 : dly;
        for (int i = 0; i < waits; i++) begin
            step();
            chk(bus_act == 1 && done == 0, "R10 still busy", int'(bus_act), 1);
        end
        case (path)
            0: begin arb_done = 1; arb_win = 0; exp_vec = 8'h0F; exp_src = 1; end
            1: begin arb_done = 1; arb_win = 1; arb_vec = 8'h80 + 8'(lvl); exp_vec = 8'h80 + lvl; exp_src = 2; end
            2: begin avec = 1; exp_vec = 8'h10 + lvl; exp_src = 3; end
            3: begin berr = 1; exp_vec = 8'h0F; exp_src = 4; end
            4: begin ext_rdy = 1; ext_data = 8'h40 + 8'(lvl * 3); exp_vec = 8'h40 + lvl * 3; exp_src = 6; end
            default: begin exp_vec = 8'h0F; exp_src = 5; end
        endcase
        step();
        clear_resp();
        chk(done == 1 && bus_act == 0, "R11 done", int'(done), 1);
        chk(vec_num == 8'(exp_vec), $sformatf("R5-path%0d vec (R6 R7 R8 R9 R10)", path), int'(vec_num), exp_vec);
        chk(int'(vec_src) == exp_src, "R5 R6 R7 R8 R9 R10 src", int'(vec_src), exp_src);
        chk(vec_addr == {8'(exp_vec), 1'b0}, "R11 vaddr", int'(vec_addr), exp_vec * 2);
        chk(sr_ipl == 3'(lvl), "R3 ipl", int'(sr_ipl), lvl);
        step();
        chk(done == 0, "R11 pulse", int'(done), 0);
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk(bus_act == 0 && done == 0 && fc == 0 && addr == 0, "R1 reset bus", int'(addr), 0);
        chk(sr_ipl == 0 && sr_pk == 0 && vec_num == 0 && vec_addr == 0 && vec_src == 0,
            "R1 reset regs", int'(vec_num), 0);

        // R4 idle write then clear on accept with simultaneous write
        pk_wr = 1; pk_wdata = 4'hA;
        step();
        pk_wr = 0;
        chk(sr_pk == 4'hA, "R4 pk write", int'(sr_pk), 10);
        pk_wr = 1; pk_wdata = 4'h5; ack_req = 1; ack_level = 3'd2;
        step();
        pk_wr = 0; ack_req = 0;
        chk(sr_pk == 0, "R4 pk clear wins", int'(sr_pk), 0);
        // R12 busy ack_req ignored
        ack_req = 1; ack_level = 3'd6;
        step();
        ack_req = 0;
        chk(addr[3:1] == 3'd2, "R12 busy req ignored", int'(addr[3:1]), 2);
        chk(sr_ipl == 3'd2, "R3 ipl after one cycle", int'(sr_ipl), 2);
        avec = 1;
        step();
        clear_resp();
        chk(vec_num == 8'h12, "R7 auto lvl2", int'(vec_num), 18);
        step();

        // R8 priority: all outcomes at once -> berr
        ack_req = 1; ack_level = 3'd5;
        step();
        ack_req = 0;
        berr = 1; avec = 1; arb_done = 1; arb_win = 1; arb_vec = 8'hAA; ext_rdy = 1; ext_data = 8'h55;
        step();
        clear_resp();
        chk(vec_src == 3'd4 && vec_num == 8'h0F, "R8 berr first", int'(vec_src), 4);
        step();
        // avec beats arbitration and ext
        ack_req = 1; ack_level = 3'd4;
        step();
        ack_req = 0;
        avec = 1; arb_done = 1; arb_win = 1; ext_rdy = 1;
        step();
        clear_resp();
        chk(vec_src == 3'd3 && vec_num == 8'h14, "R8 auto second", int'(vec_num), 20);
        step();
        // arbitration beats ext
        ack_req = 1; ack_level = 3'd3;
        step();
        ack_req = 0;
        arb_done = 1; arb_win = 1; arb_vec = 8'hC3; ext_rdy = 1;
        step();
        clear_resp();
        chk(vec_src == 3'd2 && vec_num == 8'hC3, "R8 arb over ext", int'(vec_num), 195);
        step();

        // R12 idle outcomes ignored
        berr = 1; avec = 1; arb_done = 1; ext_rdy = 1; ext_data = 8'h77;
        step();
        clear_resp();
        chk(done == 0 && vec_num == 8'hC3 && vec_src == 3'd2, "R12 idle ignore", int'(vec_num), 195);

        // sweep all levels, all paths, varied delay
        for (int lvl = 1; lvl < 8; lvl++) begin
            for (int path = 0; path < 6; path++) begin
                trial(lvl, path, (lvl + path) % 16);
            end
        end
        trial(7, 4, 15);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule